// File: doc/BRIEF.md
# Edge-Histogram Phase Picker

This block recovers data from a stream that has been oversampled three times per bit period. Each valid beat carries the three samples of one bit period. The block marks where the level changes between neighbouring samples, including the change from the last sample of one period to the first sample of the next. It counts these changes for each of the three edge positions over a fixed window of beats.

At the end of each window, the position with the strictly largest count is taken as the bit boundary. The sampling phase opposite that boundary becomes the selected phase for the next window. There is no feedback loop, so lock happens within one window.

Every valid beat produces one recovered bit one cycle later, taken at the phase that was selected when the beat arrived. The selected phase index is also driven at the output.

Top module: `edge_hist_picker`

## Requirements
- R1: Input `smp_i` holds one bit period per valid beat: bit 0 is the first sample (phase index 0), bit 1 the middle sample (index 1) and bit 2 the last sample (index 2).
- R2: Edge position 1 flags `smp_i[0]^smp_i[1]`, and edge position 2 flags `smp_i[1]^smp_i[2]`. Edge position 0 flags a change between the previous valid beat's bit 2 and the current bit 0. It is not flagged on the first valid beat after reset.
- R3: Each per-position edge count saturates at 2^CNT_W-1 and never wraps.
- R4: A window spans WIN valid beats. On the last beat of a window, the decision takes in that beat's flags, and all counts restart from zero.
- R5: When one position strictly holds the largest count at the end of a window, `phase_o` becomes that position plus one, modulo 3. Position 1 gives phase 2, position 2 gives phase 0, and position 0 gives phase 1.
- R6: When two or more positions share the largest count, `phase_o` keeps its previous value.
- R7: While `rst_ni` is low, `phase_o` is 1, `bit_valid_o` is 0 and `bit_o` is 0. Any partial window is discarded.
- R8: One cycle after a valid beat, `bit_valid_o` is 1 and `bit_o` equals the sample of that beat at the phase held in `phase_o` when the beat arrived. After a cycle without a valid beat, `bit_valid_o` is 0.
- R9: `phase_o` changes only in the cycle after the last beat of a window, and it never takes the value 3.
- R10: Cycles with `smp_valid_i` low neither advance the window nor change any count, whatever `smp_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | A bit period of samples is present |
| smp_i | input | 3 | Three samples of one bit period, earliest in bit 0 |
| bit_o | output | 1 | Recovered bit |
| bit_valid_o | output | 1 | Recovered bit strobe |
| phase_o | output | 2 | Selected sampling phase index |

## Verification
Some properties are checked on every cycle by assertions. These cover the one-cycle lag of the strobe, the recovered bit matching the sample at the held phase, and the phase staying legal and changing only after a window's last beat. They also cover counts holding at their ceiling, staying put on idle cycles and clearing after a window.

Other behaviour needs whole windows of crafted samples, so only the bench's scenarios show it. This includes which phase is picked for each dominant edge position and that a tie keeps the old choice. It also includes saturation turning a would-be winner into a tie, the first beat after reset contributing no cross-period edge, and reset discarding a partial window.

// File: rtl/edge_hist_pkg.sv
package edge_hist_pkg;
  localparam int unsigned NUM_PH = 3;
  localparam int unsigned PH_W   = 2;
  typedef logic [PH_W-1:0] ph_idx_t;
  localparam ph_idx_t PH_RESET = ph_idx_t'(1);

  // boundary at edge position k sits between phases k-1 and k; opposite phase is k+1
  function automatic ph_idx_t far_phase(ph_idx_t edge_pos);
    return (edge_pos == ph_idx_t'(NUM_PH - 1)) ? ph_idx_t'(0) : ph_idx_t'(edge_pos + 1'b1);
  endfunction
endpackage

// File: rtl/ehp_edge_det.sv
module ehp_edge_det
  import edge_hist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [NUM_PH-1:0] smp_i,
  output logic [NUM_PH-1:0] flag_o
);
  logic last_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (valid_i) begin
      last_q <= smp_i[NUM_PH-1];
      seen_q <= 1'b1;
    end
  end

  // cross-period edge needs a real previous beat
  assign flag_o[0] = seen_q & (last_q ^ smp_i[0]);

  for (genvar k = 1; k < NUM_PH; k++) begin : g_inner
    assign flag_o[k] = smp_i[k-1] ^ smp_i[k];
  end
endmodule

// File: rtl/ehp_hist.sv
module ehp_hist
  import edge_hist_pkg::*;
#(
  parameter int unsigned WIN   = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [NUM_PH-1:0]             flag_i,
  output logic [NUM_PH-1:0][CNT_W-1:0]  sum_o,
  output logic [NUM_PH-1:0][CNT_W-1:0]  cnt_o,
  output logic                          win_end_o
);
  localparam int unsigned WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WIN_W-1:0] BEAT_LAST = WIN_W'(WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [WIN_W-1:0] beat_q;

  assign win_end_o = valid_i && (beat_q == BEAT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
    end else if (valid_i) begin
      beat_q <= win_end_o ? '0 : beat_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_cnt
    logic [CNT_W-1:0] c_q;

    assign sum_o[k] = (c_q == CNT_MAX) ? CNT_MAX : c_q + CNT_W'(flag_i[k]);
    assign cnt_o[k] = c_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_q <= '0;
      end else if (valid_i) begin
        c_q <= win_end_o ? '0 : sum_o[k];
      end
    end
  end
endmodule

// File: rtl/ehp_decide.sv
module ehp_decide
  import edge_hist_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         win_end_i,
  input  logic [NUM_PH-1:0][CNT_W-1:0] sum_i,
  output ph_idx_t                      phase_o
);
  ph_idx_t          best_idx;
  logic [CNT_W-1:0] best_val;
  logic             tie;
  ph_idx_t          phase_q;

  always_comb begin
    best_idx = '0;
    best_val = sum_i[0];
    tie      = 1'b0;
    for (int k = 1; k < NUM_PH; k++) begin
      if (sum_i[k] > best_val) begin
        best_idx = ph_idx_t'(k);
        best_val = sum_i[k];
        tie      = 1'b0;
      end else if (sum_i[k] == best_val) begin
        tie = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RESET;
    end else if (win_end_i && !tie) begin
      phase_q <= far_phase(best_idx);
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/edge_hist_picker.sv
module edge_hist_picker
  import edge_hist_pkg::*;
#(
  parameter int unsigned WIN   = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [NUM_PH-1:0] smp_i,
  output logic              bit_o,
  output logic              bit_valid_o,
  output logic [PH_W-1:0]   phase_o
);
  logic [NUM_PH-1:0]            flag;
  logic [NUM_PH-1:0][CNT_W-1:0] sum_nxt;
  logic [NUM_PH-1:0][CNT_W-1:0] cnt_all;
  logic                         win_end;
  ph_idx_t                      phase_sel;

  ehp_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .smp_i   (smp_i),
    .flag_o  (flag)
  );

  ehp_hist #(.WIN(WIN), .CNT_W(CNT_W)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .flag_i    (flag),
    .sum_o     (sum_nxt),
    .cnt_o     (cnt_all),
    .win_end_o (win_end)
  );

  ehp_decide #(.CNT_W(CNT_W)) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_i (win_end),
    .sum_i     (sum_nxt),
    .phase_o   (phase_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      bit_valid_o <= smp_valid_i;
      if (smp_valid_i) bit_o <= smp_i[phase_sel];
    end
  end

  assign phase_o = phase_sel;
endmodule

// File: rtl/edge_hist_picker_chk.sv
module edge_hist_picker_chk
  import edge_hist_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         smp_valid_i,
  input logic [NUM_PH-1:0]            smp_i,
  input logic                         bit_o,
  input logic                         bit_valid_o,
  input logic [PH_W-1:0]              phase_o,
  input logic                         win_end_i,
  input logic [NUM_PH-1:0][CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_phase_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3);

  p_phase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> $past(win_end_i));

  p_strobe_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o == $past(smp_valid_i));

  p_bit_sel_r1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (bit_o == $past(smp_i[phase_o])));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(cnt_i));

  p_win_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |=> (cnt_i == '0));

  for (genvar k = 0; k < NUM_PH; k++) begin : g_sat
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_i[k]) == CNT_MAX && !$past(win_end_i)) |-> (cnt_i[k] == CNT_MAX));
  end
endmodule

bind edge_hist_picker edge_hist_picker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_i       (smp_i),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .phase_o     (phase_o),
  .win_end_i   (win_end),
  .cnt_i       (cnt_all)
);

// File: tb/edge_hist_picker_tb_top.sv
module edge_hist_picker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 8;
  localparam int CNT_W      = 3;
  localparam int NROW       = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       smp_valid_i;
  logic [2:0] smp_i;
  logic       bit_o;
  logic       bit_valid_o;
  logic [1:0] phase_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  edge_hist_picker #(.WIN(WIN), .CNT_W(CNT_W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .smp_i       (smp_i),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .phase_o     (phase_o)
  );

  // one row = one window; beat 0 in the low 3 bits, sample value bit0=first phase
  localparam logic [23:0] ROW_SMP [NROW] = '{
    {3'd1,3'd6,3'd1,3'd6,3'd1,3'd6,3'd1,3'd6},  // edges at position 1 -> phase 2
    {3'd3,3'd4,3'd3,3'd4,3'd3,3'd4,3'd3,3'd4},  // edges at position 2 -> phase 0
    {3'd0,3'd2,3'd0,3'd2,3'd0,3'd2,3'd0,3'd2},  // 4/4 tie -> keep 0
    {3'd0,3'd7,3'd0,3'd7,3'd0,3'd7,3'd0,3'd7},  // cross-period edges -> phase 1
    {3'd6,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2},  // 8 vs 7 saturates to 7/7 -> keep 1
    {3'd7,3'd0,3'd7,3'd3,3'd4,3'd3,3'd4,3'd3}   // pos2=5, pos0=3 -> phase 0
  };
  localparam logic [1:0] ROW_PH [NROW] = '{2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0};
  string row_req [NROW];

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs of this beat
  task automatic beat(input logic v, input logic [2:0] s);
    smp_valid_i = v;
    smp_i       = s;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] cur_ph;
    logic [2:0] s;
    row_req[0] = "R5";
    row_req[1] = "R5";
    row_req[2] = "R6";
    row_req[3] = "R5";
    row_req[4] = "R3";
    row_req[5] = "R5";

    rst_ni      = 1'b0;
    smp_valid_i = 1'b0;
    smp_i       = 3'd0;
    repeat (3) @(negedge clk_i);
    check("R7 phase", phase_o, 1);
    check("R7 valid", bit_valid_o, 0);
    check("R7 bit", bit_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 idle valid", bit_valid_o, 0);

    cur_ph = 2'd1;
    for (int r = 0; r < NROW; r++) begin
      for (int j = 0; j < WIN; j++) begin
        s = ROW_SMP[r][3*j +: 3];
        beat(1'b1, s);
        check("R8 valid", bit_valid_o, 1);
        check("R1 R8 bit", bit_o, s[cur_ph]);
        if (j < WIN - 1) check("R9 phase hold", phase_o, cur_ph);
        if (j == 3) begin
          beat(1'b0, 3'b101);  // junk on an idle cycle must not count
          check("R10 idle valid", bit_valid_o, 0);
          check("R10 idle phase", phase_o, cur_ph);
        end
      end
      check({row_req[r], " R4 window phase"}, phase_o, ROW_PH[r]);
      cur_ph = ROW_PH[r];
    end

    // partial window, then reset mid-run
    beat(1'b1, 3'd7);
    beat(1'b1, 3'd0);
    beat(1'b1, 3'd7);
    smp_valid_i = 1'b0;
    rst_ni      = 1'b0;
    @(negedge clk_i);
    check("R7 mid phase", phase_o, 1);
    check("R7 mid valid", bit_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // first beat after reset has no cross-period edge: pos2=1 alone wins
    cur_ph = 2'd1;
    beat(1'b1, 3'd3);
    check("R2 first bit", bit_o, 1);
    for (int j = 1; j < WIN; j++) begin
      beat(1'b1, 3'd0);
      check("R8 bit", bit_o, 0);
    end
    check("R2 first-beat phase", phase_o, 0);

    beat(1'b0, 3'd0);
    check("R8 trailing idle", bit_valid_o, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule